// File: doc/BRIEF.md
# Indirect Pointer Load Unit

This block carries out the load-through-pointer operation of a small 8-bit microcontroller datapath. It keeps two 16-bit address pointers. When an operation is accepted, the block works out an effective address from the chosen pointer. That address is either the pointer moved by one step before use, the pointer as it is (moved by one step after use), or the pointer plus a signed 6-bit displacement. The block then reads one byte from a synchronous data memory at that address.

One cycle after acceptance, the block commits three results on the same edge. The byte goes into the working register, the zero flag is recomputed, and the selected pointer takes its new value. A one-cycle done pulse marks that edge. A strobe that arrives while an operation is in flight is dropped. Software or a sequencer can load either pointer directly through a preload port.

Top module: `ind_load_unit`

## Requirements
- R1: After reset, both pointers, W and Z read 0 and done_o is low.
- R2: mode_i=2'b00 with rel_i=0 (step first, upward) reads at pointer+1 and leaves the pointer at pointer+1.
- R3: mode_i=2'b01 with rel_i=0 (step first, downward) reads at pointer-1 and leaves the pointer at pointer-1.
- R4: mode_i=2'b10 with rel_i=0 (step after, upward) reads at the unmodified pointer and leaves the pointer at pointer+1.
- R5: mode_i=2'b11 with rel_i=0 (step after, downward) reads at the unmodified pointer and leaves the pointer at pointer-1.
- R6: With rel_i=1, the read address is pointer plus offset_i, taken as 6-bit two's complement (-32..+31). The pointer is unchanged.
- R7: Pointer arithmetic is modulo 2^16: FFFFh+1 gives 0000h and 0000h-1 gives FFFFh, both for the address and for the writeback.
- R8: An operation is accepted when start_i is high and none is in flight. In that same cycle, mem_re_o is high and mem_addr_o carries the effective address.
- R9: One cycle after acceptance, W takes mem_rdata_i, Z is set exactly when that byte is 00h, the pointer writeback happens, and done_o is high for that cycle only.
- R10: sel_i=0 uses pointer 0 and sel_i=1 uses pointer 1. The other pointer is untouched.
- R11: start_i while an operation is in flight is ignored: no memory read and no second pointer update.
- R12: pre_we_i writes pre_data_i into the pointer chosen by pre_sel_i on the next edge, but only when no operation is in flight and start_i is low. Otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe |
| sel_i | input | 1 | Pointer select |
| mode_i | input | 2 | Step mode (step first/after, up/down) |
| rel_i | input | 1 | Use the signed displacement form |
| offset_i | input | 6 | Signed displacement |
| mem_re_o | output | 1 | Memory read enable |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_re_o |
| w_o | output | 8 | Working register |
| z_o | output | 1 | Zero flag |
| done_o | output | 1 | Commit pulse |
| pre_we_i | input | 1 | Pointer preload enable |
| pre_sel_i | input | 1 | Pointer preload select |
| pre_data_i | input | 16 | Pointer preload value |
| ptr0_o | output | 16 | Pointer 0 |
| ptr1_o | output | 16 | Pointer 1 |

## Verification
The memory request is combinational from the strobe, so mem_re_o and mem_addr_o are checked in the drive cycle itself, just after inputs change at the falling edge. W, Z, done_o and the updated pointer all become visible after the second rising edge. The bench therefore samples them at the second falling edge after the strobe is driven, and checks the untouched pointer at the same point. In the ignore and preload-collision cases, the extra stimulus is applied during the in-flight cycle, and the pointer is read back after the commit edge.

// File: rtl/ilu_pkg.sv
package ilu_pkg;
  typedef enum logic [1:0] {
    MODE_PRE_INC  = 2'b00,
    MODE_PRE_DEC  = 2'b01,
    MODE_POST_INC = 2'b10,
    MODE_POST_DEC = 2'b11
  } ilu_mode_e;
endpackage

// File: rtl/ilu_addr_gen.sv
module ilu_addr_gen #(
  parameter int PTR_W = 16,
  parameter int OFF_W = 6
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [1:0]       mode_i,
  input  logic             rel_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PTR_W-1:0] ea_o,
  output logic [PTR_W-1:0] nxt_o
);
  import ilu_pkg::*;
  localparam int EXT_W = PTR_W - OFF_W;

  logic [PTR_W-1:0] off_ext, stepped;
  ilu_mode_e mode;

  assign mode    = ilu_mode_e'(mode_i);
  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};

  always_comb begin
    stepped = (mode == MODE_PRE_INC || mode == MODE_POST_INC)
              ? ptr_i + PTR_W'(1) : ptr_i - PTR_W'(1);
    if (rel_i) begin
      ea_o  = ptr_i + off_ext;
      nxt_o = ptr_i;
    end else begin
      ea_o  = (mode == MODE_PRE_INC || mode == MODE_PRE_DEC) ? stepped : ptr_i;
      nxt_o = stepped;
    end
  end
endmodule

// File: rtl/ilu_ptr_file.sv
module ilu_ptr_file #(
  parameter int PTR_W   = 16,
  parameter int NUM_PTR = 2,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [PTR_W-1:0] wr_data_i,
  output logic [PTR_W-1:0] ptr_o [NUM_PTR]
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ptr_o[g] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(g))     ptr_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/ilu_result.sv
module ilu_result #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] w_o,
  output logic              z_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_o    <= '0;
      z_o    <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        w_o <= data_i;
        z_o <= (data_i == '0);
      end
    end
  end
endmodule

// File: rtl/ind_load_unit.sv
module ind_load_unit #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sel_i,
  input  logic [1:0]        mode_i,
  input  logic              rel_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              mem_re_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] w_o,
  output logic              z_o,
  output logic              done_o,
  input  logic              pre_we_i,
  input  logic              pre_sel_i,
  input  logic [PTR_W-1:0]  pre_data_i,
  output logic [PTR_W-1:0]  ptr0_o,
  output logic [PTR_W-1:0]  ptr1_o
);
  localparam int NUM_PTR = 2;

  logic             busy_q, accept;
  logic             pend_sel_q;
  logic [PTR_W-1:0] pend_ptr_q, ea, nxt, cur_ptr;
  logic [PTR_W-1:0] ptr_q [NUM_PTR];
  logic             wr_en, wr_sel;
  logic [PTR_W-1:0] wr_data;

  assign accept  = start_i & ~busy_q;
  assign cur_ptr = ptr_q[sel_i];

  ilu_addr_gen #(.PTR_W(PTR_W), .OFF_W(OFF_W)) u_addr (
    .ptr_i (cur_ptr),
    .mode_i(mode_i),
    .rel_i (rel_i),
    .off_i (offset_i),
    .ea_o  (ea),
    .nxt_o (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pend_sel_q <= 1'b0;
      pend_ptr_q <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        pend_sel_q <= sel_i;
        pend_ptr_q <= nxt;
      end
    end
  end

  // commit has priority; preload only when idle and not starting
  assign wr_en   = busy_q | (pre_we_i & ~start_i);
  assign wr_sel  = busy_q ? pend_sel_q : pre_sel_i;
  assign wr_data = busy_q ? pend_ptr_q : pre_data_i;

  ilu_ptr_file #(.PTR_W(PTR_W), .NUM_PTR(NUM_PTR)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data),
    .ptr_o    (ptr_q)
  );

  ilu_result #(.DATA_W(DATA_W)) u_res (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(busy_q),
    .data_i(mem_rdata_i),
    .w_o   (w_o),
    .z_o   (z_o),
    .done_o(done_o)
  );

  assign mem_re_o   = accept;
  assign mem_addr_o = ea;
  assign ptr0_o     = ptr_q[0];
  assign ptr1_o     = ptr_q[1];
endmodule

// File: rtl/ilu_chk.sv
module ilu_chk #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              sel_i,
  input logic [1:0]        mode_i,
  input logic              rel_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic              mem_re_o,
  input logic [PTR_W-1:0]  mem_addr_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [DATA_W-1:0] w_o,
  input logic              z_o,
  input logic              done_o,
  input logic              pre_we_i,
  input logic              pre_sel_i,
  input logic [PTR_W-1:0]  pre_data_i,
  input logic [PTR_W-1:0]  ptr0_o,
  input logic [PTR_W-1:0]  ptr1_o
);
  logic [PTR_W-1:0] sel_ptr;
  assign sel_ptr = sel_i ? ptr1_o : ptr0_o;

  assert_no_back_to_back_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  assert_done_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> ##1 done_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_zero_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (z_o == (w_o == '0)));

  assert_w_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(w_o));

  assert_post_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !rel_i && mode_i[1]) |-> (mem_addr_o == sel_ptr));

  assert_strobe_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !done_o && !$past(mem_re_o)) |-> mem_re_o);
endmodule

bind ind_load_unit ilu_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_ind_load_unit.sv
`timescale 1ns/1ps
module tb_ind_load_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, sel_i = 1'b0, rel_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [5:0]  offset_i = '0;
  logic        mem_re_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [7:0]  w_o;
  logic        z_o, done_o;
  logic        pre_we_i = 1'b0, pre_sel_i = 1'b0;
  logic [15:0] pre_data_i = '0;
  logic [15:0] ptr0_o, ptr1_o;

  int checks = 0, failures = 0;
  logic [15:0] exp_ptr [2];

  always #2 clk_i = ~clk_i;

  ind_load_unit dut (.*);

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  always @(posedge clk_i) if (mem_re_o) mem_rdata_i <= mem_f(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_ptr(input logic s);
    return s ? ptr1_o : ptr0_o;
  endfunction

  task automatic preload(input logic s, input logic [15:0] v);
    @(negedge clk_i);
    pre_we_i = 1'b1; pre_sel_i = s; pre_data_i = v;
    @(negedge clk_i);
    pre_we_i = 1'b0;
    chk(rd_ptr(s) == v, "R12 preload", rd_ptr(s), v);
    exp_ptr[s] = v;
  endtask

  task automatic run_op(input logic s, input logic [1:0] m, input logic r,
                        input logic [5:0] off, input string req);
    logic [15:0] p, ea, nxt, oth;
    logic [7:0]  d;
    p = exp_ptr[s];
    oth = exp_ptr[~s];
    if (r) begin
      ea = p + {{10{off[5]}}, off}; nxt = p;
    end else begin
      nxt = m[0] ? p - 16'd1 : p + 16'd1;
      ea  = m[1] ? p : nxt;
    end
    d = mem_f(ea);
    @(negedge clk_i);
    start_i = 1'b1; sel_i = s; mode_i = m; rel_i = r; offset_i = off;
    #1;
    chk(mem_re_o == 1'b1, {req, " R8 read enable"}, mem_re_o, 1);
    chk(mem_addr_o == ea, {req, " R8 address"}, mem_addr_o, ea);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b0, {req, " R9 done early"}, done_o, 0);
    @(negedge clk_i);
    chk(done_o == 1'b1, {req, " R9 done"}, done_o, 1);
    chk(w_o == d, {req, " R9 W"}, w_o, d);
    chk(z_o == (d == 8'h00), {req, " R9 Z"}, z_o, (d == 8'h00));
    chk(rd_ptr(s) == nxt, {req, " pointer"}, rd_ptr(s), nxt);
    chk(rd_ptr(~s) == oth, {req, " R10 other pointer"}, rd_ptr(~s), oth);
    exp_ptr[s] = nxt;
    @(negedge clk_i);
    chk(done_o == 1'b0, {req, " R9 done pulse"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk(ptr0_o == 16'h0 && ptr1_o == 16'h0, "R1 pointers", {ptr1_o, ptr0_o}, 0);
    chk(w_o == 8'h0 && z_o == 1'b0 && done_o == 1'b0, "R1 W/Z/done", {w_o, z_o, done_o}, 0);
    exp_ptr[0] = '0; exp_ptr[1] = '0;
  endtask

  task automatic t_modes;
    preload(1'b0, 16'h1000);
    preload(1'b1, 16'h2000);
    run_op(1'b0, 2'b00, 1'b0, 6'd0, "R2 R10 pre-inc p0");
    run_op(1'b1, 2'b01, 1'b0, 6'd0, "R3 R10 pre-dec p1");
    run_op(1'b0, 2'b10, 1'b0, 6'd0, "R4 post-inc p0");
    run_op(1'b1, 2'b11, 1'b0, 6'd0, "R5 post-dec p1");
  endtask

  task automatic t_relative;
    run_op(1'b0, 2'b00, 1'b1, 6'b100000, "R6 offset -32");
    run_op(1'b1, 2'b11, 1'b1, 6'b011111, "R6 offset +31");
    run_op(1'b0, 2'b10, 1'b1, 6'b000000, "R6 offset 0");
  endtask

  task automatic t_wrap;
    preload(1'b0, 16'hFFFF);
    run_op(1'b0, 2'b00, 1'b0, 6'd0, "R7 pre-inc wrap up");
    run_op(1'b0, 2'b01, 1'b0, 6'd0, "R7 pre-dec wrap down");
    run_op(1'b0, 2'b10, 1'b0, 6'd0, "R7 post-inc wrap up");
    run_op(1'b0, 2'b11, 1'b0, 6'd0, "R7 post-dec wrap down");
    preload(1'b1, 16'h0005);
    run_op(1'b1, 2'b00, 1'b1, 6'b111000, "R7 offset below zero");
  endtask

  task automatic t_busy;
    preload(1'b0, 16'h0300);
    preload(1'b1, 16'h0400);
    @(negedge clk_i);
    start_i = 1'b1; sel_i = 1'b0; mode_i = 2'b10; rel_i = 1'b0;
    @(negedge clk_i);
    mode_i = 2'b01; pre_we_i = 1'b1; pre_sel_i = 1'b1; pre_data_i = 16'hBEEF;
    #1;
    chk(mem_re_o == 1'b0, "R11 no read while busy", mem_re_o, 0);
    @(negedge clk_i);
    start_i = 1'b0; pre_we_i = 1'b0;
    chk(ptr0_o == 16'h0301, "R11 single update", ptr0_o, 16'h0301);
    chk(ptr1_o == 16'h0400, "R12 preload dropped while busy", ptr1_o, 16'h0400);
    chk(w_o == mem_f(16'h0300), "R11 W from first op", w_o, mem_f(16'h0300));
    @(negedge clk_i);
    chk(ptr0_o == 16'h0301, "R11 no second update", ptr0_o, 16'h0301);
    exp_ptr[0] = 16'h0301; exp_ptr[1] = 16'h0400;
    @(negedge clk_i);
    start_i = 1'b1; sel_i = 1'b1; mode_i = 2'b00; rel_i = 1'b1; offset_i = 6'd4;
    pre_we_i = 1'b1; pre_sel_i = 1'b1; pre_data_i = 16'h1111;
    @(negedge clk_i);
    start_i = 1'b0; pre_we_i = 1'b0;
    @(negedge clk_i);
    chk(ptr1_o == 16'h0400, "R12 preload dropped with strobe", ptr1_o, 16'h0400);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_modes();
    t_relative();
    t_wrap();
    t_busy();
    finish_run();
  end
endmodule